// File: doc/BRIEF.md
# Dual FIFO Status and DMA-Request Controller

This block sits between a processor-side bus agent and a serial shift engine. It holds two byte-wide FIFOs of 32 entries each. The bus writes outgoing bytes into the transmit FIFO and the serial engine takes them from its head. The serial engine drops incoming bytes into the receive FIFO and the bus takes them from its head. Both heads are visible combinationally, so a pop strobe both takes and advances the entry.

The controller reports the fill count of each FIFO and compares it against a programmable 6-bit level. Transmit asks for more data while it is below its level. Receive asks to be drained while it is above its level. These conditions drive per-direction DMA request lines that a DMA enable can suppress. Level conditions and overrun/underrun events on both sides are latched into a sticky flag word whose bits are cleared by writing 1. The flags are masked into a single interrupt line. A smaller wake flag set with its own mask produces a wake line. Each FIFO has its own clear command. The serial shifter, the register decoder and the DMA engine live outside.

Top module: `xfer_fifo_ctl`

## Requirements
- R1: Each FIFO holds 32 entries and reports its count (0 to 32) on `tx_count`/`rx_count`. After reset both counts are 0, all flags and wake flags are 0, and `irq`, `wake`, both heads and both DMA requests are 0.
- R2: Bytes written with `bus_wr_en` leave on `ser_tx_data` in the order written. The head is shown while the FIFO is non-empty, and `ser_tx_pop` advances it.
- R3: Bytes pushed with `ser_rx_push` appear on `bus_rd_data` in order, and `bus_rd_en` advances the head. Fullness and emptiness are judged on the count at the start of the cycle. A push to a full FIFO is discarded, even when a pop happens in the same cycle. A pop of an empty FIFO moves nothing. An empty FIFO shows 0 on its head.
- R4: Flag bit 0 sets while `tx_count < tx_level`. `tx_dma_req` is high exactly while that compare holds and `tx_dma_en` is 1. It drops in the same cycle `tx_dma_en` goes low.
- R5: Flag bit 2 sets while `rx_count > rx_level`. `rx_dma_req` is high exactly while that compare holds and `rx_dma_en` is 1.
- R6: Flag bit 1 sets while the transmit FIFO is empty. Flag bit 3 sets while the receive FIFO holds 32 entries. Each level flag appears one cycle after the count that caused it.
- R7: Bit 12 sets on a bus write to a full transmit FIFO. Bit 13 sets on a serial pop of an empty transmit FIFO. Bit 14 sets on a serial push to a full receive FIFO. Bit 15 sets on a bus read of an empty receive FIFO. Each is visible the cycle after the event. Bits 4 to 11 stay 0.
- R8: A 1 in `evt_clr` clears the matching flag bit. If that bit's set condition is active in the same cycle, the bit stays set.
- R9: `tx_clear` empties the transmit FIFO and zeroes flag bits 0, 1, 12 and 13 and wake bits 0 and 1. `rx_clear` does the same for the receive FIFO, flag bits 2, 3, 14 and 15 and wake bits 2 and 3. A clear overrides any push, pop or set in the same cycle.
- R10: With `tx_fifo_en` low, `ser_tx_pop` is ignored and raises no underrun. With `rx_fifo_en` low, `ser_rx_push` is ignored and raises no overrun. Bus-side access still works in both cases.
- R11: `irq` is the OR over all bits of `evt_flags & evt_irq_en`, with no added delay.
- R12: Wake bits are set by the same conditions as flag bits: bit 0 by the transmit level, bit 1 by transmit empty, bit 2 by the receive level and bit 3 by receive full. They are cleared by writing 1 to `wake_clr`, with set winning. `wake` is the OR of `wake_flags & wake_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus push into transmit FIFO |
| bus_wr_data | input | 8 | Byte to push into transmit FIFO |
| bus_rd_en | input | 1 | Bus pop from receive FIFO |
| bus_rd_data | output | 8 | Receive FIFO head, 0 when empty |
| ser_tx_pop | input | 1 | Serial pop from transmit FIFO |
| ser_tx_data | output | 8 | Transmit FIFO head, 0 when empty |
| ser_rx_push | input | 1 | Serial push into receive FIFO |
| ser_rx_data | input | 8 | Byte to push into receive FIFO |
| tx_fifo_en | input | 1 | Allows serial access to transmit FIFO |
| rx_fifo_en | input | 1 | Allows serial access to receive FIFO |
| tx_clear | input | 1 | Empty transmit FIFO and its status |
| rx_clear | input | 1 | Empty receive FIFO and its status |
| tx_level | input | 6 | Transmit threshold level |
| rx_level | input | 6 | Receive threshold level |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_count | output | 6 | Transmit FIFO entry count |
| rx_count | output | 6 | Receive FIFO entry count |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| evt_flags | output | 16 | Sticky event flags |
| evt_clr | input | 16 | Write-1-to-clear strobes for evt_flags |
| evt_irq_en | input | 16 | Per-flag interrupt enables |
| irq | output | 1 | Masked interrupt |
| wake_flags | output | 4 | Sticky wake flags |
| wake_clr | input | 4 | Write-1-to-clear strobes for wake_flags |
| wake_en | input | 4 | Per-flag wake enables |
| wake | output | 1 | Masked wake request |

## Verification
The bench drives the transmit FIFO two entries past full and the receive FIFO one entry past full. A design that judged fullness after a same-cycle pop, or that let the extra write wrap the pointer, would corrupt the head byte or miss the overrun bit. It writes 1 to the empty flag while the FIFO is still empty; a design where clear beat set would drop a condition that is still true. It asserts a FIFO clear together with a push and expects an empty FIFO with its four side flags wiped. It holds the serial enables low during pops and pushes; a leaky enable would move the count or raise a spurious underrun. A long random phase with mixed levels, clears and strobes is then compared cycle by cycle against a queue-based model.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

    localparam int FLAG_W = 16;
    localparam int WAKE_W = 4;

    // flag positions decoded by software
    localparam int F_TX_LVL   = 0;
    localparam int F_TX_EMPTY = 1;
    localparam int F_RX_LVL   = 2;
    localparam int F_RX_FULL  = 3;
    localparam int F_TX_OVR   = 12;
    localparam int F_TX_UND   = 13;
    localparam int F_RX_OVR   = 14;
    localparam int F_RX_UND   = 15;

    localparam int SIDE_TX = 0;
    localparam int SIDE_RX = 1;

    // per-direction status captured each cycle
    typedef struct packed {
        logic lvl;    // threshold compare true
        logic bound;  // empty (TX) or full (RX)
        logic ovr;    // push into full FIFO
        logic und;    // pop from empty FIFO
    } side_evt_t;

    function automatic logic cnt_below(int unsigned cnt, int unsigned lvl);
        return cnt < lvl;
    endfunction

    function automatic logic cnt_above(int unsigned cnt, int unsigned lvl);
        return cnt > lvl;
    endfunction

    function automatic logic [FLAG_W-1:0] pack_flags(side_evt_t tx, side_evt_t rx);
        logic [FLAG_W-1:0] f;
        f             = '0;
        f[F_TX_LVL]   = tx.lvl;
        f[F_TX_EMPTY] = tx.bound;
        f[F_TX_OVR]   = tx.ovr;
        f[F_TX_UND]   = tx.und;
        f[F_RX_LVL]   = rx.lvl;
        f[F_RX_FULL]  = rx.bound;
        f[F_RX_OVR]   = rx.ovr;
        f[F_RX_UND]   = rx.und;
        return f;
    endfunction

    function automatic logic [WAKE_W-1:0] pack_wake(side_evt_t tx, side_evt_t rx);
        return {rx.bound, rx.lvl, tx.bound, tx.lvl};
    endfunction

    function automatic logic [FLAG_W-1:0] side_mask(int unsigned side);
        logic [FLAG_W-1:0] m;
        m = '0;
        if (side == SIDE_TX) begin
            m[F_TX_LVL] = 1'b1; m[F_TX_EMPTY] = 1'b1;
            m[F_TX_OVR] = 1'b1; m[F_TX_UND]   = 1'b1;
        end else begin
            m[F_RX_LVL] = 1'b1; m[F_RX_FULL]  = 1'b1;
            m[F_RX_OVR] = 1'b1; m[F_RX_UND]   = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          ovr_evt,
    output logic          und_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign ovr_evt = push && full;
    assign und_evt = pop && empty;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

endmodule

// File: rtl/xfer_w1c_bank.sv
module xfer_w1c_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] w1c,
    input  logic [W-1:0] wipe,
    output logic [W-1:0] q
);
    // wipe beats set, set beats write-1-to-clear
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~w1c) | set) & ~wipe;
    end
endmodule

// File: rtl/xfer_fifo_ctl.sv
module xfer_fifo_ctl
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int LVL_W = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [DW-1:0]     bus_wr_data,
    input  logic              bus_rd_en,
    output logic [DW-1:0]     bus_rd_data,
    input  logic              ser_tx_pop,
    output logic [DW-1:0]     ser_tx_data,
    input  logic              ser_rx_push,
    input  logic [DW-1:0]     ser_rx_data,
    input  logic              tx_fifo_en,
    input  logic              rx_fifo_en,
    input  logic              tx_clear,
    input  logic              rx_clear,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_dma_en,
    input  logic              rx_dma_en,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic [FLAG_W-1:0] evt_flags,
    input  logic [FLAG_W-1:0] evt_clr,
    input  logic [FLAG_W-1:0] evt_irq_en,
    output logic              irq,
    output logic [WAKE_W-1:0] wake_flags,
    input  logic [WAKE_W-1:0] wake_clr,
    input  logic [WAKE_W-1:0] wake_en,
    output logic              wake
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0] f_push, f_pop, f_clr, f_ovr, f_und;
    logic [DW-1:0]    f_din  [NSIDE];
    logic [DW-1:0]    f_head [NSIDE];
    logic [CNT_W-1:0] f_cnt  [NSIDE];

    // side routing: bus feeds TX, serial feeds RX; serial access gated
    assign f_push[SIDE_TX] = bus_wr_en;
    assign f_din[SIDE_TX]  = bus_wr_data;
    assign f_pop[SIDE_TX]  = ser_tx_pop && tx_fifo_en;
    assign f_clr[SIDE_TX]  = tx_clear;
    assign f_push[SIDE_RX] = ser_rx_push && rx_fifo_en;
    assign f_din[SIDE_RX]  = ser_rx_data;
    assign f_pop[SIDE_RX]  = bus_rd_en;
    assign f_clr[SIDE_RX]  = rx_clear;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        xfer_byte_fifo #(
            .DEPTH (DEPTH),
            .DW    (DW),
            .CW    (CNT_W)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .clr       (f_clr[s]),
            .push      (f_push[s]),
            .push_data (f_din[s]),
            .pop       (f_pop[s]),
            .head      (f_head[s]),
            .count     (f_cnt[s]),
            .ovr_evt   (f_ovr[s]),
            .und_evt   (f_und[s])
        );
    end

    assign ser_tx_data = f_head[SIDE_TX];
    assign bus_rd_data = f_head[SIDE_RX];
    assign tx_count    = f_cnt[SIDE_TX];
    assign rx_count    = f_cnt[SIDE_RX];

    side_evt_t tx_st, rx_st;

    always_comb begin
        tx_st.lvl   = cnt_below(32'(f_cnt[SIDE_TX]), 32'(tx_level));
        tx_st.bound = (f_cnt[SIDE_TX] == '0);
        tx_st.ovr   = f_ovr[SIDE_TX];
        tx_st.und   = f_und[SIDE_TX];
        rx_st.lvl   = cnt_above(32'(f_cnt[SIDE_RX]), 32'(rx_level));
        rx_st.bound = (f_cnt[SIDE_RX] == CNT_W'(DEPTH));
        rx_st.ovr   = f_ovr[SIDE_RX];
        rx_st.und   = f_und[SIDE_RX];
    end

    assign tx_dma_req = tx_dma_en && tx_st.lvl;
    assign rx_dma_req = rx_dma_en && rx_st.lvl;

    logic [FLAG_W-1:0] evt_wipe;
    logic [WAKE_W-1:0] wake_wipe;

    assign evt_wipe  = (tx_clear ? side_mask(SIDE_TX) : '0)
                     | (rx_clear ? side_mask(SIDE_RX) : '0);
    assign wake_wipe = {rx_clear, rx_clear, tx_clear, tx_clear};

    xfer_w1c_bank #(.W(FLAG_W)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .set  (pack_flags(tx_st, rx_st)),
        .w1c  (evt_clr),
        .wipe (evt_wipe),
        .q    (evt_flags)
    );

    xfer_w1c_bank #(.W(WAKE_W)) u_wake (
        .clk  (clk),
        .rst  (rst),
        .set  (pack_wake(tx_st, rx_st)),
        .w1c  (wake_clr),
        .wipe (wake_wipe),
        .q    (wake_flags)
    );

    assign irq  = |(evt_flags & evt_irq_en);
    assign wake = |(wake_flags & wake_en);

endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic              ser_tx_pop,
    input logic              tx_fifo_en,
    input logic              tx_clear,
    input logic              rx_clear,
    input logic              tx_dma_en,
    input logic              tx_dma_req,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic [FLAG_W-1:0] evt_flags,
    input logic [FLAG_W-1:0] evt_irq_en,
    input logic              irq,
    input logic [WAKE_W-1:0] wake_en,
    input logic              wake
);
    // R1
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_count) <= DEPTH) && (32'(rx_count) <= DEPTH));

    // R4
    dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_dma_en |-> !tx_dma_req);

    // R6
    tx_empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count == '0) && !tx_clear |=> evt_flags[F_TX_EMPTY]);

    // R7
    tx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && (32'(tx_count) == DEPTH) && !tx_clear |=> evt_flags[F_TX_OVR]);

    // R8
    rx_underrun_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && (rx_count == '0) && !rx_clear |=> evt_flags[F_RX_UND]);

    // R9
    tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tx_clear |=> (tx_count == '0) && !evt_flags[F_TX_OVR] && !evt_flags[F_TX_UND]);

    // R10
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_fifo_en && ser_tx_pop && !bus_wr_en && !tx_clear |=> tx_count == $past(tx_count));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_irq_en == '0) |-> !irq);

    // R12
    wake_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_en == '0) |-> !wake);

endmodule

bind xfer_fifo_ctl xfer_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .ser_tx_pop (ser_tx_pop),
    .tx_fifo_en (tx_fifo_en),
    .tx_clear   (tx_clear),
    .rx_clear   (rx_clear),
    .tx_dma_en  (tx_dma_en),
    .tx_dma_req (tx_dma_req),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .evt_flags  (evt_flags),
    .evt_irq_en (evt_irq_en),
    .irq        (irq),
    .wake_en    (wake_en),
    .wake       (wake)
);

// File: tb/xfer_fifo_ctl_tb.sv
module xfer_fifo_ctl_tb;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en, bus_rd_en, ser_tx_pop, ser_rx_push;
    logic [7:0]  bus_wr_data, ser_rx_data, bus_rd_data, ser_tx_data;
    logic        tx_fifo_en, rx_fifo_en, tx_clear, rx_clear;
    logic [5:0]  tx_level, rx_level;
    logic        tx_dma_en, rx_dma_en, tx_dma_req, rx_dma_req;
    logic [5:0]  tx_count, rx_count;
    logic [15:0] evt_flags, evt_clr, evt_irq_en;
    logic        irq, wake;
    logic [3:0]  wake_flags, wake_clr, wake_en;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5ns clk = ~clk;

    xfer_fifo_ctl u_dut (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
        .tx_clear(tx_clear), .rx_clear(rx_clear),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .evt_flags(evt_flags), .evt_clr(evt_clr), .evt_irq_en(evt_irq_en), .irq(irq),
        .wake_flags(wake_flags), .wake_clr(wake_clr), .wake_en(wake_en), .wake(wake)
    );

    // behavioural reference model
    logic [7:0]  mtx[$];
    logic [7:0]  mrx[$];
    logic [15:0] mflags;
    logic [3:0]  mwake;

    always @(posedge clk) begin
        int c, r;
        logic [15:0] s;
        if (rst) begin
            mtx.delete(); mrx.delete();
            mflags = '0; mwake = '0;
        end else begin
            c = mtx.size();
            r = mrx.size();
            s = '0;
            s[0]  = c < int'(tx_level);
            s[1]  = (c == 0);
            s[2]  = r > int'(rx_level);
            s[3]  = (r == DEPTH);
            s[12] = bus_wr_en && (c == DEPTH);
            s[13] = tx_fifo_en && ser_tx_pop && (c == 0);
            s[14] = rx_fifo_en && ser_rx_push && (r == DEPTH);
            s[15] = bus_rd_en && (r == 0);
            mflags = (mflags & ~evt_clr) | s;
            mwake  = (mwake & ~wake_clr) | {s[3], s[2], s[1], s[0]};
            if (tx_clear) begin
                mflags &= ~16'h3003; mwake &= 4'hC; mtx.delete();
            end else begin
                if (tx_fifo_en && ser_tx_pop && c > 0) void'(mtx.pop_front());
                if (bus_wr_en && c < DEPTH) mtx.push_back(bus_wr_data);
            end
            if (rx_clear) begin
                mflags &= ~16'hC00C; mwake &= 4'h3; mrx.delete();
            end else begin
                if (bus_rd_en && r > 0) void'(mrx.pop_front());
                if (rx_fifo_en && ser_rx_push && r < DEPTH) mrx.push_back(ser_rx_data);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [7:0]  eh_tx, eh_rx;
        logic [15:0] ef;
        eh_tx = (mtx.size() > 0) ? mtx[0] : 8'h00;
        eh_rx = (mrx.size() > 0) ? mrx[0] : 8'h00;
        ef    = mflags;
        chk("R1 tx_count", 32'(tx_count), 32'(mtx.size()));
        chk("R1 rx_count", 32'(rx_count), 32'(mrx.size()));
        chk("R2 ser_tx_data", 32'(ser_tx_data), 32'(eh_tx));
        chk("R3 bus_rd_data", 32'(bus_rd_data), 32'(eh_rx));
        chk("R4 tx_dma_req", 32'(tx_dma_req),
            32'(tx_dma_en && (mtx.size() < int'(tx_level))));
        chk("R4 flag0", 32'(evt_flags[0]), 32'(ef[0]));
        chk("R5 rx_dma_req", 32'(rx_dma_req),
            32'(rx_dma_en && (mrx.size() > int'(rx_level))));
        chk("R5 flag2", 32'(evt_flags[2]), 32'(ef[2]));
        chk("R6 flags1_3", 32'({evt_flags[3], evt_flags[1]}), 32'({ef[3], ef[1]}));
        chk("R7 flags15_4", 32'(evt_flags[15:4]), 32'(ef[15:4]));
        chk("R11 irq", 32'(irq), 32'(|(ef & evt_irq_en)));
        chk("R12 wake_flags", 32'(wake_flags), 32'(mwake));
        chk("R12 wake", 32'(wake), 32'(|(mwake & wake_en)));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        bus_wr_en = 0; bus_rd_en = 0; ser_tx_pop = 0; ser_rx_push = 0;
        bus_wr_data = 0; ser_rx_data = 0;
        tx_fifo_en = 0; rx_fifo_en = 0; tx_clear = 0; rx_clear = 0;
        tx_level = 0; rx_level = 0; tx_dma_en = 0; rx_dma_en = 0;
        evt_clr = 0; evt_irq_en = 0; wake_clr = 0; wake_en = 0;
        repeat (3) tick();
        // reset state
        chk("R1 reset flags", 32'(evt_flags), 0);
        chk("R1 reset wake_flags", 32'(wake_flags), 0);
        chk("R1 reset counts", 32'({tx_count, rx_count}), 0);

        rst = 0;
        tx_fifo_en = 1; rx_fifo_en = 1;
        tx_level = 6'd4; rx_level = 6'd2;
        tx_dma_en = 1; rx_dma_en = 1;
        evt_irq_en = 16'hF00F; wake_en = 4'hF;

        // five bytes through the transmit path
        for (int i = 0; i < 5; i++) begin
            bus_wr_en = 1; bus_wr_data = 8'hA0 + 8'(i); tick();
        end
        bus_wr_en = 0; tick();
        chk("R2 head first", 32'(ser_tx_data), 32'h A0);
        chk("R4 no req at 5", 32'(tx_dma_req), 0);
        ser_tx_pop = 1; tick();
        chk("R2 head second", 32'(ser_tx_data), 32'h A1);
        tick();
        ser_tx_pop = 0; tick();
        chk("R4 req below level", 32'(tx_dma_req), 1);

        // fill transmit FIFO and write two beyond full
        for (int i = 0; i < 31; i++) begin
            bus_wr_en = 1; bus_wr_data = 8'h10 + 8'(i); tick();
        end
        bus_wr_en = 0;
        chk("R7 tx overrun", 32'(evt_flags[12]), 1);
        chk("R3 full count", 32'(tx_count), 32);
        chk("R3 head kept", 32'(ser_tx_data), 32'h A2);

        // serial pops blocked by enable
        tx_fifo_en = 0; ser_tx_pop = 1;
        repeat (3) tick();
        chk("R10 tx pop ignored", 32'(tx_count), 32);
        ser_tx_pop = 0; tx_fifo_en = 1;

        // clear with a concurrent push
        tx_clear = 1; bus_wr_en = 1; bus_wr_data = 8'h55; tick();
        tx_clear = 0; bus_wr_en = 0;
        chk("R9 count cleared", 32'(tx_count), 0);
        chk("R9 side flags wiped", 32'({evt_flags[13:12], evt_flags[1:0]}), 0);
        tick();
        chk("R6 tx empty", 32'(evt_flags[1]), 1);

        // write-1-to-clear while condition still holds
        evt_clr = 16'h0003; tick();
        evt_clr = 0;
        chk("R8 set wins", 32'(evt_flags[1:0]), 3);
        bus_wr_en = 1; bus_wr_data = 8'h77; tick();
        bus_wr_en = 0;
        evt_clr = 16'h0002; tick();
        evt_clr = 0;
        chk("R8 cleared", 32'(evt_flags[1]), 0);

        // receive path past full
        for (int i = 0; i < 33; i++) begin
            ser_rx_push = 1; ser_rx_data = 8'hB0 + 8'(i); tick();
        end
        ser_rx_push = 0;
        chk("R6 rx full", 32'(evt_flags[3]), 1);
        chk("R7 rx overrun", 32'(evt_flags[14]), 1);
        chk("R3 rx head", 32'(bus_rd_data), 32'h B0);
        rx_fifo_en = 0; ser_rx_push = 1; ser_rx_data = 8'hEE;
        repeat (2) tick();
        ser_rx_push = 0; rx_fifo_en = 1;
        chk("R10 rx push ignored", 32'(rx_count), 32);
        for (int i = 0; i < 33; i++) begin
            bus_rd_en = 1; tick();
        end
        bus_rd_en = 0;
        chk("R7 rx underrun", 32'(evt_flags[15]), 1);
        chk("R3 empty head zero", 32'(bus_rd_data), 0);

        // DMA disable drops the request
        tx_dma_en = 0; tick();
        chk("R4 dma disabled", 32'(tx_dma_req), 0);
        tx_dma_en = 1;

        chk("R11 irq on", 32'(irq), 1);
        evt_irq_en = 0; tick();
        chk("R11 irq masked", 32'(irq), 0);
        evt_irq_en = 16'hFFFF;

        wake_clr = 4'h8; tick();
        wake_clr = 0;
        chk("R12 wake full cleared", 32'(wake_flags[3]), 0);
        chk("R12 wake active", 32'(wake), 1);

        // random phase against the model
        for (int ph = 0; ph < 16; ph++) begin
            for (int k = 0; k < 200; k++) begin
                bus_wr_en   = ($urandom_range(0, 9) < ((ph % 2) ? 2 : 7));
                ser_tx_pop  = ($urandom_range(0, 9) < ((ph % 2) ? 7 : 2));
                ser_rx_push = ($urandom_range(0, 9) < ((ph % 2) ? 2 : 7));
                bus_rd_en   = ($urandom_range(0, 9) < ((ph % 2) ? 7 : 2));
                bus_wr_data = 8'($urandom);
                ser_rx_data = 8'($urandom);
                tx_fifo_en  = ($urandom_range(0, 15) != 0);
                rx_fifo_en  = ($urandom_range(0, 15) != 0);
                tx_clear    = ($urandom_range(0, 99) == 0);
                rx_clear    = ($urandom_range(0, 99) == 0);
                evt_clr     = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
                wake_clr    = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
                if ($urandom_range(0, 49) == 0) begin
                    tx_level   = 6'($urandom);
                    rx_level   = 6'($urandom);
                    tx_dma_en  = 1'($urandom);
                    rx_dma_en  = 1'($urandom);
                    evt_irq_en = 16'($urandom);
                    wake_en    = 4'($urandom);
                end
                tick();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule